// File: doc/BRIEF.md
# External Memory Bus Cycle Timer

This block times the bus cycles for one chip-select region of an external memory bus. An internal master raises a request carrying address, write flag, write data and byte enables, and holds it until the block answers with a one-clock acknowledge. For each request the block decodes the region from three upper address bits and then runs the cycle. Chip select is driven first for a programmable setup time. The output-enable or per-lane write strobes are then held for the programmed wait count, and the external device can stretch them through an active-low ready pin. A programmable hold time follows, with chip select still asserted.

Three access styles exist. A single SRAM-style access moves one word. A burst read moves a fixed number of beats back to back and keeps the strobe active while the word address steps. A card-style access takes its setup and hold from separate 2-bit codes and adds an extra wait count on top of the base one. The timing configuration is sampled when a request is accepted and stays fixed until that request is acknowledged.

Top module: `ext_bus_timer`

## Requirements
- R1: Chip select is asserted only for requests whose address bits [28:26] equal 3'b101. A request outside that region asserts no chip select and no strobe, and is acknowledged in the first cycle after acceptance.
- R2: The base wait code w[2:0] gives W wait cycles: W = w for codes 0 to 3, and W = 3*(w-2) for codes 4 to 7 (6, 9, 12, 15). With ready asserted, a single access holds its strobe for 1+W cycles.
- R3: In SRAM and burst modes (mode 0, 1; mode 3 acts as 0), chip select is asserted for 0 or 1 cycle (setup bit) before the strobe starts.
- R4: In SRAM and burst modes, chip select stays asserted for 0 to 3 cycles (2-bit hold field) after the strobe ends.
- R5: The active-low ready input is sampled on the last programmed strobe cycle and on each cycle after it. While ready is high the strobe is extended one cycle at a time.
- R6: A write drives write-enable lane i low for the whole strobe exactly when byte enable i is set, and keeps output enable high. A read drives output enable low and all write enables high. Output enable and write enables are never active together, and never active outside chip select.
- R7: In card mode (mode 2), setup is the 2-bit setup code in cycles (0 to 3), hold is the 2-bit hold code (0 to 3), and the strobe lasts 1 + W + E cycles, where E is 0, 15, 30 or 50 for extra-wait codes 0 to 3.
- R8: A burst read (mode 1) makes 4 beats with the strobe held active throughout. The first beat lasts 1+W cycles, each later beat lasts min(W,7)+2 cycles, and the word address advances by 8 bytes per beat.
- R9: Read data is captured on the clock edge that ends each beat's strobe and is presented with a one-cycle read-valid pulse in the next cycle. The acknowledge pulses for one cycle right after the last hold cycle, with chip select already released.
- R10: After reset, chip select, output enable and all write enables are high, and acknowledge and read-valid are low.
- R11: A write in burst mode is carried out as one single access with SRAM timing and produces no read-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until acknowledge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Byte address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables, one per lane |
| cfg_mode | input | 2 | 0 SRAM, 1 burst read, 2 card, 3 same as SRAM |
| cfg_wait_code | input | 3 | Base wait code |
| cfg_setup | input | 1 | Setup cycles, SRAM and burst modes |
| cfg_hold | input | 2 | Hold cycles, SRAM and burst modes |
| cfg_card_setup | input | 2 | Card-mode setup code |
| cfg_card_hold | input | 2 | Card-mode hold code |
| cfg_card_wait | input | 2 | Card-mode extra wait code |
| mem_ready_n | input | 1 | Active-low ready from the device |
| mem_rdata | input | 64 | Read data from the device |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe / output enable, active low |
| mem_we_n | output | 8 | Per-lane write strobes, active low |
| mem_addr | output | 29 | Address driven to the device |
| mem_wdata | output | 64 | Write data driven to the device |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Captured read data |
| ack | output | 1 | Request completion pulse |

## Verification
Cycles are counted from the edge that accepts the request. The setup cycles occupy cycles 1..S, the strobe runs to cycle S+L, the hold ends at S+L+H, and the acknowledge falls in cycle S+L+H+1. Each read-valid pulse comes one cycle after its beat's final strobe cycle. The bench samples every output at the falling edge and counts the observed cycles of each phase against these arithmetic targets. It also changes the device read data on every cycle, so a capture taken one edge early or late returns the wrong word. Ready is held high from the falling edge of each early strobe cycle, which sets the value seen at the closing edge and produces a known stretch.

// File: rtl/ebt_pkg.sv
package ebt_pkg;

  localparam int TW_W = 7;  // widest phase count: 15 + 50

  typedef enum logic [1:0] {
    MODE_SRAM  = 2'd0,
    MODE_BURST = 2'd1,
    MODE_CARD  = 2'd2,
    MODE_ALT   = 2'd3
  } bus_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD,
    ST_ACK
  } phase_e;

  typedef struct packed {
    logic [1:0]      setup;
    logic [TW_W-1:0] waits;
    logic [1:0]      hold;
    logic [3:0]      beat;
    logic            burst;
  } timing_t;

  function automatic logic [3:0] base_wait(input logic [2:0] code);
    case (code)
      3'd4:    base_wait = 4'd6;
      3'd5:    base_wait = 4'd9;
      3'd6:    base_wait = 4'd12;
      3'd7:    base_wait = 4'd15;
      default: base_wait = {1'b0, code};
    endcase
  endfunction

  function automatic logic [5:0] card_extra(input logic [1:0] code);
    case (code)
      2'd1:    card_extra = 6'd15;
      2'd2:    card_extra = 6'd30;
      2'd3:    card_extra = 6'd50;
      default: card_extra = 6'd0;
    endcase
  endfunction

endpackage

// File: rtl/ebt_area_decode.sv
module ebt_area_decode #(
  parameter int ADDR_W   = 29,
  parameter int AREA_LSB = 26,
  parameter int AREA_W   = 3,
  parameter int AREA_ID  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam logic [AREA_W-1:0] ID = AREA_W'(AREA_ID);

  always_comb hit = (addr[AREA_LSB +: AREA_W] == ID);
endmodule

// File: rtl/ebt_timing_calc.sv
module ebt_timing_calc
  import ebt_pkg::*;
(
  input  logic [1:0] cfg_mode,
  input  logic [2:0] cfg_wait_code,
  input  logic       cfg_setup,
  input  logic [1:0] cfg_hold,
  input  logic [1:0] cfg_card_setup,
  input  logic [1:0] cfg_card_hold,
  input  logic [1:0] cfg_card_wait,
  input  logic       is_write,
  output timing_t    tim
);
  logic [3:0] base;
  logic       card;

  always_comb begin
    base       = base_wait(cfg_wait_code);
    card       = (cfg_mode == MODE_CARD);
    tim.setup  = card ? cfg_card_setup : {1'b0, cfg_setup};
    tim.hold   = card ? cfg_card_hold : cfg_hold;
    tim.waits  = TW_W'(base) + (card ? TW_W'(card_extra(cfg_card_wait)) : TW_W'(0));
    tim.beat   = ((base > 4'd7) ? 4'd7 : base) + 4'd2;
    tim.burst  = (cfg_mode == MODE_BURST) && !is_write;
  end
endmodule

// File: rtl/ebt_sequencer.sv
module ebt_sequencer
  import ebt_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int DATA_W   = 64,
  parameter int BEATS    = 4,
  parameter int AREA_LSB = 26,
  parameter int AREA_W   = 3,
  parameter int AREA_ID  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic                req_hit,
  input  timing_t             req_tim,
  input  logic                mem_ready_n,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                ack
);
  localparam int LANES  = DATA_W / 8;
  localparam int BCNT_W = $clog2(BEATS + 1);

  phase_e              state, nxt;
  logic [TW_W-1:0]     cnt, cnt_nxt;
  timing_t             tim_q;
  logic                wr_q;
  logic [LANES-1:0]    be_q;
  logic [BCNT_W-1:0]   beats_left;
  logic                capture, advance, accept;
  logic                nwr;
  logic [LANES-1:0]    nbe;

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt;
    capture = 1'b0;
    advance = 1'b0;
    accept  = (state == ST_IDLE) && req_valid;
    case (state)
      ST_IDLE: if (req_valid) begin
        if (!req_hit) nxt = ST_ACK;
        else if (req_tim.setup != 2'd0) begin
          nxt     = ST_SETUP;
          cnt_nxt = TW_W'(req_tim.setup) - TW_W'(1);
        end else begin
          nxt     = ST_STROBE;
          cnt_nxt = req_tim.waits;
        end
      end
      ST_SETUP: begin
        if (cnt == '0) begin
          nxt     = ST_STROBE;
          cnt_nxt = tim_q.waits;
        end else cnt_nxt = cnt - TW_W'(1);
      end
      ST_STROBE: begin
        if (cnt != '0) cnt_nxt = cnt - TW_W'(1);
        else if (!mem_ready_n) begin
          capture = !wr_q;
          if (tim_q.burst && beats_left != '0) begin
            advance = 1'b1;
            cnt_nxt = TW_W'(tim_q.beat) - TW_W'(1);
          end else if (tim_q.hold != 2'd0) begin
            nxt     = ST_HOLD;
            cnt_nxt = TW_W'(tim_q.hold) - TW_W'(1);
          end else nxt = ST_ACK;
        end
      end
      ST_HOLD: begin
        if (cnt == '0) nxt = ST_ACK;
        else cnt_nxt = cnt - TW_W'(1);
      end
      default: nxt = ST_IDLE;
    endcase
    nwr = accept ? req_write : wr_q;
    nbe = accept ? req_be : be_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      tim_q      <= '0;
      wr_q       <= 1'b0;
      be_q       <= '0;
      beats_left <= '0;
      mem_cs_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= '1;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      ack        <= 1'b0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
      if (accept) begin
        tim_q      <= req_tim;
        wr_q       <= req_write;
        be_q       <= req_be;
        mem_addr   <= req_addr;
        mem_wdata  <= req_wdata;
        beats_left <= BCNT_W'(BEATS - 1);
      end
      if (advance) begin
        mem_addr   <= mem_addr + ADDR_W'(LANES);
        beats_left <= beats_left - BCNT_W'(1);
      end
      mem_cs_n <= !(nxt == ST_SETUP || nxt == ST_STROBE || nxt == ST_HOLD);
      mem_oe_n <= !(nxt == ST_STROBE && !nwr);
      mem_we_n <= (nxt == ST_STROBE && nwr) ? ~nbe : '1;
      ack      <= (nxt == ST_ACK);
      rd_valid <= capture;
      if (capture) rd_data <= mem_rdata;
    end
  end

  // R9: acknowledge lasts a single cycle
  a_r9_ack_single: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack);

  // R9: chip select already released in the acknowledge cycle
  a_r9_ack_cs_released: assert property (@(posedge clk) disable iff (rst)
    ack |-> mem_cs_n);

  // R6: read and write strobes never overlap
  a_r6_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(!mem_oe_n && (mem_we_n != '1)));

  // R6: any strobe lies inside chip select
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!mem_oe_n || (mem_we_n != '1)) |-> !mem_cs_n);

  // R1: chip select only for addresses inside the region
  a_r1_cs_in_area: assert property (@(posedge clk) disable iff (rst)
    !mem_cs_n |-> (mem_addr[AREA_LSB +: AREA_W] == AREA_W'(AREA_ID)));

  // R5: ready high at the closing strobe cycle keeps the strobe going
  a_r5_ready_extends: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STROBE && cnt == '0 && mem_ready_n)
      |=> (state == ST_STROBE && $stable(mem_addr) && !mem_cs_n));

endmodule

// File: rtl/ext_bus_timer.sv
module ext_bus_timer
  import ebt_pkg::*;
#(
  parameter int ADDR_W   = 29,
  parameter int DATA_W   = 64,
  parameter int BEATS    = 4,
  parameter int AREA_LSB = 26,
  parameter int AREA_W   = 3,
  parameter int AREA_ID  = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [1:0]          cfg_mode,
  input  logic [2:0]          cfg_wait_code,
  input  logic                cfg_setup,
  input  logic [1:0]          cfg_hold,
  input  logic [1:0]          cfg_card_setup,
  input  logic [1:0]          cfg_card_hold,
  input  logic [1:0]          cfg_card_wait,
  input  logic                mem_ready_n,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic                mem_cs_n,
  output logic                mem_oe_n,
  output logic [DATA_W/8-1:0] mem_we_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic                ack
);
  logic    hit;
  timing_t tim;

  ebt_area_decode #(
    .ADDR_W(ADDR_W), .AREA_LSB(AREA_LSB), .AREA_W(AREA_W), .AREA_ID(AREA_ID)
  ) i_decode (
    .addr(req_addr),
    .hit (hit)
  );

  ebt_timing_calc i_calc (
    .cfg_mode      (cfg_mode),
    .cfg_wait_code (cfg_wait_code),
    .cfg_setup     (cfg_setup),
    .cfg_hold      (cfg_hold),
    .cfg_card_setup(cfg_card_setup),
    .cfg_card_hold (cfg_card_hold),
    .cfg_card_wait (cfg_card_wait),
    .is_write      (req_write),
    .tim           (tim)
  );

  ebt_sequencer #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BEATS(BEATS),
    .AREA_LSB(AREA_LSB), .AREA_W(AREA_W), .AREA_ID(AREA_ID)
  ) i_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .req_be     (req_be),
    .req_hit    (hit),
    .req_tim    (tim),
    .mem_ready_n(mem_ready_n),
    .mem_rdata  (mem_rdata),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rd_valid   (rd_valid),
    .rd_data    (rd_data),
    .ack        (ack)
  );
endmodule

// File: tb/test_ext_bus_timer.sv
module test_ext_bus_timer;
  localparam int CLK_PERIOD = 10;
  localparam int BEATS      = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [28:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [7:0]  req_be = '0;
  logic [1:0]  cfg_mode = '0;
  logic [2:0]  cfg_wait_code = '0;
  logic        cfg_setup = 1'b0;
  logic [1:0]  cfg_hold = '0, cfg_card_setup = '0, cfg_card_hold = '0, cfg_card_wait = '0;
  logic        mem_ready_n = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        mem_cs_n, mem_oe_n, rd_valid, ack;
  logic [7:0]  mem_we_n;
  logic [28:0] mem_addr;
  logic [63:0] mem_wdata, rd_data;

  int nchecks = 0, nerrors = 0, gcyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_bus_timer i_ext_bus_timer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .cfg_mode(cfg_mode), .cfg_wait_code(cfg_wait_code), .cfg_setup(cfg_setup),
    .cfg_hold(cfg_hold), .cfg_card_setup(cfg_card_setup), .cfg_card_hold(cfg_card_hold),
    .cfg_card_wait(cfg_card_wait), .mem_ready_n(mem_ready_n), .mem_rdata(mem_rdata),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rd_valid(rd_valid), .rd_data(rd_data), .ack(ack)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_base(input int code);
    return (code < 4) ? code : 3 * (code - 2);
  endfunction

  function automatic int exp_extra(input int code);
    return (code == 3) ? 50 : 15 * code;
  endfunction

  task automatic do_access(input int mode, input int wc, input int su, input int ho,
                           input int csu, input int cho, input int cwt,
                           input bit wr, input logic [28:0] addr, input logic [7:0] be,
                           input int ext);
    bit    card  = (mode == 2);
    bit    burst = (mode == 1) && !wr;
    bit    hit   = (addr[28:26] == 3'b101);
    int    w     = exp_base(wc) + (card ? exp_extra(cwt) : 0);
    int    s     = card ? csu : su;
    int    h     = card ? cho : ho;
    int    nb    = burst ? BEATS : 1;
    int    blen[BEATS];
    int    slen[BEATS];
    logic [63:0] last_d[BEATS];
    logic [63:0] rv_d[BEATS];
    int    rv_cyc[BEATS];
    int    nrv = 0, cyc = 0, ack_cyc = -1, cs_total = 0, setup_seen = 0, hold_seen = 0;
    int    lane_bad = 0, cum = 0;
    bit    seen_strobe = 0;
    string rs, rst_, rh, rw;
    rs  = card ? "R7" : "R3";
    rh  = card ? "R7" : "R4";
    rst_ = card ? "R7" : (wr && mode == 1) ? "R11" : (ext != 0) ? "R5" : "R2";
    rw  = "R6";
    for (int k = 0; k < BEATS; k++) begin
      blen[k] = (k == 0) ? 1 + w + ext : ((w > 7) ? 7 : w) + 2;
      slen[k] = 0; last_d[k] = '0; rv_d[k] = '0; rv_cyc[k] = 0;
    end
    @(negedge clk);
    cfg_mode = 2'(mode); cfg_wait_code = 3'(wc); cfg_setup = 1'(su); cfg_hold = 2'(ho);
    cfg_card_setup = 2'(csu); cfg_card_hold = 2'(cho); cfg_card_wait = 2'(cwt);
    req_write = wr; req_addr = addr; req_be = be;
    req_wdata = {32'hC0DE_0000 + 32'(gcyc), 32'(gcyc) * 32'd13};
    req_valid = 1'b1; mem_ready_n = 1'b0;
    while (ack_cyc < 0 && cyc < 400) begin
      bit strobe;
      @(negedge clk);
      cyc++; gcyc++;
      strobe = !mem_oe_n || (mem_we_n != 8'hFF);
      mem_rdata = {16'hA5C3, 16'(gcyc), 32'(gcyc) * 32'd7 + 32'd3};
      if (!mem_cs_n) cs_total++;
      if (!mem_cs_n && !strobe && !seen_strobe) setup_seen++;
      if (!mem_cs_n && !strobe && seen_strobe) hold_seen++;
      if (strobe) begin
        int idx = int'((mem_addr - addr) >> 3);
        seen_strobe = 1;
        if (wr ? (mem_we_n != ~be || !mem_oe_n) : (mem_oe_n || mem_we_n != 8'hFF)) lane_bad++;
        if (idx >= 0 && idx < BEATS) begin
          slen[idx]++;
          last_d[idx] = mem_rdata;
          mem_ready_n = (idx == 0 && slen[idx] < 1 + w + ext);
        end else begin
          lane_bad++;
          mem_ready_n = 1'b0;
        end
      end else mem_ready_n = 1'b0;
      if (rd_valid) begin
        if (nrv < BEATS) begin
          rv_d[nrv] = rd_data; rv_cyc[nrv] = cyc;
        end
        nrv++;
      end
      if (ack) ack_cyc = cyc;
    end
    req_valid = 1'b0;
    mem_ready_n = 1'b0;
    if (!hit) begin
      check(cs_total == 0, "R1", "chip select outside region", cs_total, 0);
      check(ack_cyc == 1, "R1", "ack cycle outside region", ack_cyc, 1);
      check(nrv == 0, "R1", "read valid outside region", nrv, 0);
      return;
    end
    check(setup_seen == s, rs, "setup cycles", setup_seen, s);
    for (int k = 0; k < nb; k++)
      check(slen[k] == blen[k], (nb > 1) ? "R8" : rst_, "strobe cycles of beat", slen[k], blen[k]);
    check(hold_seen == h, rh, "hold cycles", hold_seen, h);
    check(lane_bad == 0, rw, "strobe lane pattern errors", lane_bad, 0);
    for (int k = 0; k < nb; k++) cum += blen[k];
    check(ack_cyc == s + cum + h + 1, "R9", "ack cycle", ack_cyc, s + cum + h + 1);
    if (wr) begin
      check(nrv == 0, (mode == 1) ? "R11" : "R6", "read valid on write", nrv, 0);
    end else begin
      check(nrv == nb, (nb > 1) ? "R8" : "R9", "read valid count", nrv, nb);
      cum = 0;
      for (int k = 0; k < nb && k < nrv; k++) begin
        cum += blen[k];
        check(rv_d[k] == last_d[k], "R9", "captured data", rv_d[k], last_d[k]);
        check(rv_cyc[k] == s + cum + 1, "R9", "read valid cycle", rv_cyc[k], s + cum + 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchecks++; nerrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end

  initial begin
    logic [28:0] in_area;
    in_area = {3'b101, 26'h0_0100};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: idle outputs after reset
    check(mem_cs_n && mem_oe_n && (mem_we_n == 8'hFF), "R10", "strobes idle", {mem_cs_n, mem_oe_n, mem_we_n}, 10'h3FF);
    check(!ack && !rd_valid, "R10", "ack and read valid low", {ack, rd_valid}, 0);

    // R2, R3, R4, R6, R9: SRAM sweep over wait code, setup, hold, direction
    for (int wc = 0; wc < 8; wc++)
      for (int su = 0; su < 2; su++)
        for (int ho = 0; ho < 4; ho++)
          for (int wr = 0; wr < 2; wr++)
            do_access((wc == 3) ? 3 : 0, wc, su, ho, 0, 0, 0, 1'(wr), in_area,
                      8'(8'h5A ^ 8'(wc * 17 + ho)), 0);

    // R5: ready stretch
    for (int ext = 1; ext < 4; ext++)
      for (int wc = 0; wc < 8; wc += 3)
        for (int wr = 0; wr < 2; wr++)
          do_access(0, wc, 1, 1, 0, 0, 0, 1'(wr), in_area, 8'hF0, ext);

    // R7: card mode sweep
    for (int csu = 0; csu < 4; csu++)
      for (int cho = 0; cho < 4; cho++)
        for (int cwt = 0; cwt < 4; cwt++)
          for (int wr = 0; wr < 2; wr++)
            do_access(2, (cwt == 2) ? 7 : csu, 1, 3, csu, cho, cwt, 1'(wr), in_area, 8'h3C, 0);

    // R8 and R11: burst reads and burst-mode writes
    for (int wc = 0; wc < 8; wc++)
      for (int wr = 0; wr < 2; wr++)
        do_access(1, wc, wc % 2, wc % 4, 0, 0, 0, 1'(wr), in_area, 8'h81, 0);

    // R1: requests outside the region
    do_access(0, 2, 1, 2, 0, 0, 0, 1'b0, {3'b100, 26'h0_0040}, 8'hFF, 0);
    do_access(0, 2, 1, 2, 0, 0, 0, 1'b1, {3'b111, 26'h0_0040}, 8'hFF, 0);
    do_access(1, 5, 0, 0, 0, 0, 0, 1'b0, {3'b001, 26'h0_0080}, 8'hFF, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrors);
    $finish;
  end
endmodule